// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible control state of a multi-channel DMA controller. It sits on a simple 32-bit bus that uses byte offsets and transfers whole words. A request lasts one cycle and carries a valid strobe, a write flag, an offset and write data. Every request gets its response on the next cycle, and that response is registered. Offsets below the channel base (0x20) select five global words: a control word, two interrupt mask words and two interrupt source words, at 0x00, 0x04, 0x08, 0x0C and 0x10. Offsets from the base upward select a 32-byte bank per channel. The channel number is (offset - 0x20) / 0x20. The word within the bank is the remainder divided by four.

Each bank holds eight words: control/status at 0x00, transfer size at 0x04, source address at 0x08, source mask at 0x0C, destination address at 0x10, destination mask at 0x14, descriptor pointer at 0x18 and software pointer at 0x1C. Software can write only the low ten control bits. The busy and done bits come from the transfer engine. Four sticky event bits are set by the engine and cleared as a side effect of a software read of that control word. Every register value is driven out in parallel so that the transfer engine can use it.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register reads zero, except the source mask and destination mask of every channel, which read 0xFFFFFFFC.
- R2: A bank word at offset 0x20 + 0x20*c + 4*k (k = 0..7 in the order listed above) is written and read back per channel; writes to one channel leave the others unchanged.
- R3: A write to a channel control word changes only bits 9:0. Bits 31:10 keep their value.
- R4: A read of a channel control word returns the value held before the read. It then clears bits 15:12 and leaves all other bits unchanged.
- R5: When eng_upd[c] is high, bit 10 of channel c takes eng_busy[c] and bit 11 takes eng_done[c]. Each high bit j of eng_set[c] sets bit 12+j: ERR, chunk event, done event and error event.
- R6: When an engine set and a read-clear of the same control word fall in the same cycle, the read returns the old value and the newly set bit remains set afterwards.
- R7: The interrupt mask and source words are fully read/write. The global control word stores bits 31:1, and bit 0 (pause) always reads zero.
- R8: A misaligned offset, a global offset above 0x10, or a bank of a channel at or beyond NUM_CH is illegal. It leaves every register unchanged, a read of it returns zero, and rsp_err is high for exactly the response cycle.
- R9: rsp_valid goes high for one cycle, exactly one cycle after each read request, and never for a write.
- R10: The parallel outputs always equal the values that software reads at the matching offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal access pulse |
| eng_upd | input | NUM_CH | Load busy/done for a channel |
| eng_busy | input | NUM_CH | Busy value from the engine |
| eng_done | input | NUM_CH | Done value from the engine |
| eng_set | input | NUM_CH x 4 | Sticky event set pulses |
| ch_csr_o | output | NUM_CH x 32 | Channel control/status |
| ch_size_o | output | NUM_CH x 32 | Transfer size |
| ch_src_o | output | NUM_CH x 32 | Source address |
| ch_src_mask_o | output | NUM_CH x 32 | Source address mask |
| ch_dst_o | output | NUM_CH x 32 | Destination address |
| ch_dst_mask_o | output | NUM_CH x 32 | Destination address mask |
| ch_desc_o | output | NUM_CH x 32 | Descriptor pointer |
| ch_swptr_o | output | NUM_CH x 32 | Software pointer |
| glb_ctrl_o | output | 32 | Global control word |
| irq_mask_a_o | output | 32 | Interrupt mask A |
| irq_mask_b_o | output | 32 | Interrupt mask B |
| irq_src_a_o | output | 32 | Interrupt source A |
| irq_src_b_o | output | 32 | Interrupt source B |

## Verification
Two functions of this block can fall in the same cycle: a software read that clears a control word's sticky bits, and an engine pulse that sets one of those bits. The bench provokes this by driving the read of channel 1's control word and an eng_set pulse for that channel on the same clock edge. The queued expected value is the state before the event. A second read must then show the event bit, and a third read must show it cleared, which proves the event was neither lost nor reported early.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BANK_WORDS = 8;
  localparam int unsigned GLB_WORDS = 5;
  localparam logic [WORD_W-1:0] CSR_WMASK = 32'h0000_03FF;
  localparam logic [WORD_W-1:0] CSR_CLRMASK = 32'h0000_F000;
  localparam int unsigned CSR_BUSY_BIT = 10;
  localparam int unsigned CSR_DONE_BIT = 11;
  localparam int unsigned CSR_EVT_LSB = 12;
  localparam logic [WORD_W-1:0] MASK_RST = 32'hFFFF_FFFC;

  typedef enum logic [2:0] {
    BR_CSR, BR_SIZE, BR_SRC, BR_SRCMSK, BR_DST, BR_DSTMSK, BR_DESC, BR_SWPTR
  } bank_reg_e;

  typedef enum logic [2:0] {
    GR_CTRL, GR_MSKA, GR_MSKB, GR_SRCA, GR_SRCB, GR_RSV5, GR_RSV6, GR_RSV7
  } glb_reg_e;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned CH_BASE    = 32,
  parameter int unsigned BANK_BYTES = 32,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned BANK_SH   = $clog2(BANK_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_glob,
  output logic [2:0]        glob_idx,
  output logic [CH_W-1:0]   ch_idx,
  output logic [2:0]        reg_idx,
  output logic              legal
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] ch_full;
  logic [ADDR_W-1:0] gword;
  logic [ADDR_W-1:0] bword;

  always_comb begin
    off      = addr - ADDR_W'(CH_BASE);
    ch_full  = off >> BANK_SH;
    gword    = addr >> 2;
    bword    = (off & ADDR_W'(BANK_BYTES - 1)) >> 2;
    is_glob  = (32'(addr) < CH_BASE);
    glob_idx = gword[2:0];
    ch_idx   = ch_full[CH_W-1:0];
    reg_idx  = bword[2:0];
    if (addr[1:0] != 2'b00)
      legal = 1'b0;
    else if (is_glob)
      legal = (32'(gword) < dma_rf_pkg::GLB_WORDS);
    else
      legal = (32'(ch_full) < NUM_CH) && ((32'(bword) >> 3) == 0);
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_clr,
  input  logic [2:0]                    reg_idx,
  input  logic [WORD_W-1:0]             wdata,
  input  logic                          eng_upd,
  input  logic                          eng_busy,
  input  logic                          eng_done,
  input  logic [3:0]                    eng_set,
  output logic [BANK_WORDS-1:0][WORD_W-1:0] bank_q
);
  logic [WORD_W-1:0] csr_nxt;

  always_comb begin
    csr_nxt = bank_q[BR_CSR];
    if (wr_en && reg_idx == BR_CSR)
      csr_nxt = (csr_nxt & ~CSR_WMASK) | (wdata & CSR_WMASK);
    if (rd_clr)
      csr_nxt = csr_nxt & ~CSR_CLRMASK;
    if (eng_upd) begin
      csr_nxt[CSR_BUSY_BIT] = eng_busy;
      csr_nxt[CSR_DONE_BIT] = eng_done;
    end
    csr_nxt[CSR_EVT_LSB +: 4] = csr_nxt[CSR_EVT_LSB +: 4] | eng_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < BANK_WORDS; k++) bank_q[k] <= '0;
      bank_q[BR_SRCMSK] <= MASK_RST;
      bank_q[BR_DSTMSK] <= MASK_RST;
    end else begin
      bank_q[BR_CSR] <= csr_nxt;
      for (int k = 1; k < BANK_WORDS; k++)
        if (wr_en && 32'(reg_idx) == k) bank_q[k] <= wdata;
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned CH_BASE    = 32,
  parameter int unsigned BANK_BYTES = 32,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [31:0]                    req_wdata,
  output logic                           rsp_valid,
  output logic [31:0]                    rsp_rdata,
  output logic                           rsp_err,
  input  logic [NUM_CH-1:0]              eng_upd,
  input  logic [NUM_CH-1:0]              eng_busy,
  input  logic [NUM_CH-1:0]              eng_done,
  input  logic [NUM_CH-1:0][3:0]         eng_set,
  output logic [NUM_CH-1:0][31:0]        ch_csr_o,
  output logic [NUM_CH-1:0][31:0]        ch_size_o,
  output logic [NUM_CH-1:0][31:0]        ch_src_o,
  output logic [NUM_CH-1:0][31:0]        ch_src_mask_o,
  output logic [NUM_CH-1:0][31:0]        ch_dst_o,
  output logic [NUM_CH-1:0][31:0]        ch_dst_mask_o,
  output logic [NUM_CH-1:0][31:0]        ch_desc_o,
  output logic [NUM_CH-1:0][31:0]        ch_swptr_o,
  output logic [31:0]                    glb_ctrl_o,
  output logic [31:0]                    irq_mask_a_o,
  output logic [31:0]                    irq_mask_b_o,
  output logic [31:0]                    irq_src_a_o,
  output logic [31:0]                    irq_src_b_o
);
  logic            is_glob;
  logic [2:0]      glob_idx;
  logic [CH_W-1:0] ch_idx;
  logic [2:0]      reg_idx;
  logic            legal;
  logic [NUM_CH-1:0][BANK_WORDS-1:0][31:0] banks;
  logic [GLB_WORDS-1:0][31:0] glb_q;
  logic [31:0]     rd_mux;
  logic            ok_acc;

  dma_rf_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .BANK_BYTES(BANK_BYTES)
  ) u_dec (
    .addr(req_addr), .is_glob(is_glob), .glob_idx(glob_idx),
    .ch_idx(ch_idx), .reg_idx(reg_idx), .legal(legal)
  );

  assign ok_acc = req_valid && legal;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = ok_acc && !is_glob && (32'(ch_idx) == c);
    dma_rf_chan u_chan (
      .clk(clk), .rst(rst),
      .wr_en(hit && req_write),
      .rd_clr(hit && !req_write && reg_idx == BR_CSR),
      .reg_idx(reg_idx), .wdata(req_wdata),
      .eng_upd(eng_upd[c]), .eng_busy(eng_busy[c]), .eng_done(eng_done[c]),
      .eng_set(eng_set[c]), .bank_q(banks[c])
    );
    assign ch_csr_o[c]      = banks[c][BR_CSR];
    assign ch_size_o[c]     = banks[c][BR_SIZE];
    assign ch_src_o[c]      = banks[c][BR_SRC];
    assign ch_src_mask_o[c] = banks[c][BR_SRCMSK];
    assign ch_dst_o[c]      = banks[c][BR_DST];
    assign ch_dst_mask_o[c] = banks[c][BR_DSTMSK];
    assign ch_desc_o[c]     = banks[c][BR_DESC];
    assign ch_swptr_o[c]    = banks[c][BR_SWPTR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q <= '0;
    end else if (ok_acc && is_glob && req_write) begin
      for (int g = 0; g < GLB_WORDS; g++)
        if (32'(glob_idx) == g)
          glb_q[g] <= (g == GR_CTRL) ? {req_wdata[31:1], 1'b0} : req_wdata;
    end
  end

  assign glb_ctrl_o   = glb_q[GR_CTRL];
  assign irq_mask_a_o = glb_q[GR_MSKA];
  assign irq_mask_b_o = glb_q[GR_MSKB];
  assign irq_src_a_o  = glb_q[GR_SRCA];
  assign irq_src_b_o  = glb_q[GR_SRCB];

  always_comb begin
    rd_mux = '0;
    if (legal) begin
      if (is_glob) begin
        for (int g = 0; g < GLB_WORDS; g++)
          if (32'(glob_idx) == g) rd_mux = glb_q[g];
      end else begin
        for (int c = 0; c < NUM_CH; c++)
          if (32'(ch_idx) == c) rd_mux = banks[c][reg_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      rsp_err   <= req_valid && !legal;
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_write,
  input logic                    rsp_valid,
  input logic [31:0]             rsp_rdata,
  input logic                    rsp_err,
  input logic [NUM_CH-1:0]       eng_upd,
  input logic [NUM_CH-1:0][3:0]  eng_set,
  input logic [NUM_CH-1:0][31:0] ch_csr_o,
  input logic [NUM_CH-1:0][31:0] ch_size_o,
  input logic [NUM_CH-1:0][31:0] ch_src_o,
  input logic [NUM_CH-1:0][31:0] ch_dst_mask_o,
  input logic [31:0]             glb_ctrl_o
);
  a_r9_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  a_r8_err_follows_req: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid));

  a_r8_err_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_err && rsp_valid) |-> (rsp_rdata == 32'h0));

  a_r8_err_no_change: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> ($stable(ch_size_o) && $stable(ch_src_o) && $stable(ch_dst_mask_o)));

  a_r7_pause_zero: assert property (@(posedge clk) disable iff (rst)
    glb_ctrl_o[0] == 1'b0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ca
    a_r5_r6_event_kept: assert property (@(posedge clk) disable iff (rst)
      ($past(eng_set[c]) != 4'h0) |->
        ((ch_csr_o[c][15:12] & $past(eng_set[c])) == $past(eng_set[c])));
    a_r5_status_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(eng_upd[c]) |-> $stable(ch_csr_o[c][11:10]));
  end
endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .eng_upd(eng_upd), .eng_set(eng_set), .ch_csr_o(ch_csr_o),
  .ch_size_o(ch_size_o), .ch_src_o(ch_src_o), .ch_dst_mask_o(ch_dst_mask_o),
  .glb_ctrl_o(glb_ctrl_o)
);

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NUM_CH-1:0] eng_upd = '0, eng_busy = '0, eng_done = '0;
  logic [NUM_CH-1:0][3:0] eng_set = '0;
  logic [NUM_CH-1:0][31:0] ch_csr_o, ch_size_o, ch_src_o, ch_src_mask_o;
  logic [NUM_CH-1:0][31:0] ch_dst_o, ch_dst_mask_o, ch_desc_o, ch_swptr_o;
  logic [31:0] glb_ctrl_o, irq_mask_a_o, irq_mask_b_o, irq_src_a_o, irq_src_b_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] data; bit err; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dma_regfile #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dma_regfile (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) chk(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_rdata === e.data, e.tag, rsp_rdata, e.data);
        chk(rsp_err === e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input bit e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    sb.push_back('{exp, e, tag});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_err === e, {tag, " err"}, 32'(rsp_err), 32'(e));
    chk(rsp_valid === 1'b0, "R9 no response on write", 32'(rsp_valid), 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(8'h2C, 32'hFFFFFFFC, 0, "R1 ch0 src mask");
    rd(8'h94, 32'hFFFFFFFC, 0, "R1 ch3 dst mask");
    rd(8'h48, 32'h0, 0, "R1 ch1 src");
    rd(8'h04, 32'h0, 0, "R1 mask A");
    chk(ch_src_mask_o[2] == 32'hFFFFFFFC, "R1 R10 ch2 src mask port", ch_src_mask_o[2], 32'hFFFFFFFC);
    // R2 bank map
    wr(8'h28, 32'h1234_5678, 0, "R2 ch0 src");
    wr(8'h98, 32'hCAFE_0010, 0, "R2 ch3 desc");
    wr(8'h5C, 32'h0000_00A5, 0, "R2 ch1 swptr");
    rd(8'h28, 32'h1234_5678, 0, "R2 ch0 src");
    rd(8'h98, 32'hCAFE_0010, 0, "R2 ch3 desc");
    rd(8'h5C, 32'h0000_00A5, 0, "R2 ch1 swptr");
    rd(8'h48, 32'h0, 0, "R2 ch1 src untouched");
    chk(ch_desc_o[3] == 32'hCAFE_0010, "R10 ch3 desc port", ch_desc_o[3], 32'hCAFE_0010);
    // R3 write mask
    wr(8'h60, 32'hFFFF_FFFF, 0, "R3 ch2 csr");
    rd(8'h60, 32'h0000_03FF, 0, "R3 ch2 csr masked");
    // R5 engine status
    @(negedge clk); eng_upd[2] = 1'b1; eng_busy[2] = 1'b1;
    @(negedge clk); eng_upd[2] = 1'b0; eng_busy[2] = 1'b0;
    rd(8'h60, 32'h0000_07FF, 0, "R5 busy set");
    @(negedge clk); eng_set[2] = 4'b0011;
    @(negedge clk); eng_set[2] = 4'b0000;
    chk(ch_csr_o[2] == 32'h0000_37FF, "R5 R10 sticky port", ch_csr_o[2], 32'h0000_37FF);
    // R4 read clears
    rd(8'h60, 32'h0000_37FF, 0, "R4 read returns sticky");
    rd(8'h60, 32'h0000_07FF, 0, "R4 sticky cleared");
    wr(8'h60, 32'h0, 0, "R3 csr clear");
    rd(8'h60, 32'h0000_0400, 0, "R3 busy kept on write");
    // R6 collision on channel 1
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h40; eng_set[1] = 4'b0100;
    sb.push_back('{32'h0, 1'b0, "R6 collision read old"});
    @(negedge clk);
    req_valid = 1'b0; eng_set[1] = 4'b0000;
    rd(8'h40, 32'h0000_4000, 0, "R6 event kept");
    rd(8'h40, 32'h0, 0, "R6 event cleared");
    // R7 globals
    wr(8'h04, 32'h0000_0005, 0, "R7 mask A");
    wr(8'h10, 32'h8000_0001, 0, "R7 src B");
    rd(8'h04, 32'h0000_0005, 0, "R7 mask A");
    rd(8'h10, 32'h8000_0001, 0, "R7 src B");
    wr(8'h00, 32'hFFFF_FFFF, 0, "R7 ctrl");
    rd(8'h00, 32'hFFFF_FFFE, 0, "R7 pause ignored");
    chk(glb_ctrl_o == 32'hFFFF_FFFE, "R7 ctrl port", glb_ctrl_o, 32'hFFFF_FFFE);
    // R8 illegal accesses
    rd(8'h29, 32'h0, 1, "R8 misaligned read");
    wr(8'h2A, 32'hDEAD_BEEF, 1, "R8 misaligned write");
    rd(8'h28, 32'h1234_5678, 0, "R8 src unchanged");
    rd(8'h14, 32'h0, 1, "R8 undefined global read");
    wr(8'h18, 32'h1111_1111, 1, "R8 undefined global write");
    rd(8'hA8, 32'h0, 1, "R8 channel out of range");
    wr(8'hA8, 32'h2222_2222, 1, "R8 channel out of range write");
    rd(8'h00, 32'hFFFF_FFFE, 0, "R8 ctrl unchanged");
    // R9 back-to-back reads
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h08;
    sb.push_back('{32'h0, 1'b0, "R9 b2b first"});
    @(negedge clk);
    req_addr = 8'h10;
    sb.push_back('{32'h8000_0001, 1'b0, "R9 b2b second"});
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R9 all responses seen", 32'(sb.size()), 32'h0);
    finish_run();
  end
endmodule